// File: doc/BRIEF.md
# SD Host Interrupt Status Block

This block collects the event pulses produced by the command, data and card-detect logic of an SD host controller and turns them into one interrupt line toward the processor. It has two status registers: one for normal events and one for errors. Each status register has two enable layers. A status-enable mask decides whether an incoming pulse is latched at all. A signal-enable mask decides whether a latched bit may raise the interrupt line.

Software reaches all six registers over a small synchronous register bus. Reads are combinational from the selected address. A write takes effect on the next clock edge. Status bits are acknowledged by writing ones to them. The normal status register also carries a read-only summary bit that reports whether any error status bit is latched.

The interrupt line is driven by a two-state machine. In `IRQ_QUIET` the line is low. The machine moves `IRQ_QUIET -> IRQ_RAISED` on the edge where any status bit is set together with its signal enable. It moves `IRQ_RAISED -> IRQ_QUIET` on the edge where no such bit remains. In every other case it stays in its state. The line is therefore a register output that follows the status by exactly one cycle.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The normal status register (address 0) latches a pulse on `norm_evt[i]` into bit i at the clock edge where the pulse is sampled, when status-enable bit i is one. The pulse must arrive with status-enable bit i already one. Bit positions are: 0 command done, 1 transfer done, 2 block gap, 3 DMA boundary, 4 write buffer ready, 5 read buffer ready, 6 card inserted, 7 card removed, 8 card interrupt.
- R3: A pulse whose status-enable bit is zero is never latched.
- R4: The four enable registers read back what was last written, limited to their implemented bits. The addresses are 2 normal status enable, 3 error status enable, 4 normal signal enable, 5 error signal enable. Normal enables implement bits 8:0 and error enables implement bits ERR_W-1:0. All other bits read zero.
- R5: A write to a status register clears exactly the bits written as one. Bits written as zero keep their value.
- R6: When a latched pulse and a write-one-to-clear of the same bit fall on the same edge, the bit ends up set.
- R7: The error status register (address 1) latches `err_evt[i]` into bit i, gated by error status-enable bit i. Bit 0 is command timeout and bit 1 is data timeout, and the two are independent.
- R8: Bit 15 of the normal status register reads one exactly when any error status bit is set. Writes to bit 15 have no effect.
- R9: `irq` is high in the cycle after a cycle in which some status bit and its signal-enable bit are both one. `irq` lags the status by one cycle.
- R10: Clearing the error signal-enable register takes `irq` low without changing the latched error status.
- R11: `irq` returns low one cycle after the last signal-enabled status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| norm_evt | input | 9 | Single-cycle normal event pulses |
| err_evt | input | ERR_W | Single-cycle error event pulses |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a pulse and a write-one-to-clear on the same bit in the same edge. The bench lines up an event pulse with a bus write to that status register in one cycle. It then checks the bit on the following read.

Equally awkward is the one-cycle lag of `irq` behind status changes. This lag appears both on the way up and on the way down. Masking through the error signal enable must leave the error status intact.

A long phase of random pulses and sparse random writes runs with a behavioural model. The model is compared on every edge, which covers the overlaps that the directed steps do not.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int REG_W   = 16;
    localparam int NORM_W  = 9;
    localparam int SUM_BIT = 15;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_NSTAT = 3'd0,
        SEL_ESTAT = 3'd1,
        SEL_NSEN  = 3'd2,
        SEL_ESEN  = 3'd3,
        SEL_NSIG  = 3'd4,
        SEL_ESIG  = 3'd5
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/sdh_stat_bank.sv
module sdh_stat_bank #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         sen_wr,
    input  logic         sig_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] sen,
    output logic [W-1:0] sig,
    output logic         pend
);
    logic [W-1:0] hit;
    logic [W-1:0] clr;

    assign hit = evt & sen;
    assign clr = clr_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sen <= '0;
            sig <= '0;
        end else begin
            if (sen_wr) sen <= wdata;
            if (sig_wr) sig <= wdata;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stat[i] <= 1'b0;
            else if (hit[i]) stat[i] <= 1'b1;
            else if (clr[i]) stat[i] <= 1'b0;
        end
    end

    assign pend = |(stat & sig);

    a_r3_no_latch_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(evt & sen)) == '0));
    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & sen) != '0) |=> ((stat & $past(evt & sen)) == $past(evt & sen)));
    a_r5_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat & $past(wdata & ~(evt & sen))) == '0));
endmodule

// File: rtl/sdh_irq_fsm.sv
module sdh_irq_fsm
    import sdh_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
            default:                  state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    a_r9_irq_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(pending)));
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NORM_W-1:0]        norm_evt,
    input  logic [ERR_W-1:0]         err_evt,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     irq
);
    localparam int PAD_W = SUM_BIT - NORM_W;

    logic [NORM_W-1:0] n_stat, n_sen, n_sig;
    logic [ERR_W-1:0]  e_stat, e_sen, e_sig;
    logic              n_pend, e_pend, err_any;

    sdh_stat_bank #(.W(NORM_W)) u_norm (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (norm_evt),
        .sen_wr (reg_wr && reg_addr == SEL_NSEN),
        .sig_wr (reg_wr && reg_addr == SEL_NSIG),
        .clr_wr (reg_wr && reg_addr == SEL_NSTAT),
        .wdata  (reg_wdata[NORM_W-1:0]),
        .stat   (n_stat),
        .sen    (n_sen),
        .sig    (n_sig),
        .pend   (n_pend)
    );

    sdh_stat_bank #(.W(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (err_evt),
        .sen_wr (reg_wr && reg_addr == SEL_ESEN),
        .sig_wr (reg_wr && reg_addr == SEL_ESIG),
        .clr_wr (reg_wr && reg_addr == SEL_ESTAT),
        .wdata  (reg_wdata[ERR_W-1:0]),
        .stat   (e_stat),
        .sen    (e_sen),
        .sig    (e_sig),
        .pend   (e_pend)
    );

    assign err_any = |e_stat;

    sdh_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (n_pend | e_pend),
        .irq     (irq)
    );

    always_comb begin
        unique case (reg_addr)
            SEL_NSTAT: reg_rdata = {err_any, {PAD_W{1'b0}}, n_stat};
            SEL_ESTAT: reg_rdata = REG_W'(e_stat);
            SEL_NSEN:  reg_rdata = REG_W'(n_sen);
            SEL_ESEN:  reg_rdata = REG_W'(e_sen);
            SEL_NSIG:  reg_rdata = REG_W'(n_sig);
            SEL_ESIG:  reg_rdata = REG_W'(e_sig);
            default:   reg_rdata = '0;
        endcase
    end

    a_r10_masked_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((e_sig == '0) && ((n_stat & n_sig) == '0)) |=> !irq);
    a_r10_mask_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_ESIG) |=> ((e_stat & $past(e_stat)) == $past(e_stat)
                                             || $past(reg_wr && reg_addr == SEL_ESTAT)));
    a_r8_summary_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_any) |-> ($past(err_evt & e_sen) != '0));
endmodule

// File: tb/test_sdh_irq_status.sv
`timescale 1ns/1ps
module test_sdh_irq_status;
    localparam int EW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  norm_evt = '0;
    logic [EW-1:0] err_evt = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit live   = 1'b0;
    bit done   = 1'b0;

    logic [8:0]    mn, mnen, mnsig;
    logic [EW-1:0] me, meen, mesig;
    logic          mirq;

    always #4 clk = ~clk;

    sdh_irq_status #(.ERR_W(EW)) i_sdh_irq_status (
        .clk(clk), .rst_n(rst_n), .norm_evt(norm_evt), .err_evt(err_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return {|me, 6'b0, mn};
            3'd1:    return 16'(me);
            3'd2:    return 16'(mnen);
            3'd3:    return 16'(meen);
            3'd4:    return 16'(mnsig);
            3'd5:    return 16'(mesig);
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model, compared before every update
    always @(posedge clk) begin
        logic pend;
        logic [8:0] nclr;
        logic [EW-1:0] eclr;
        if (!rst_n) begin
            mn = '0; mnen = '0; mnsig = '0;
            me = '0; meen = '0; mesig = '0; mirq = 1'b0;
        end else begin
            if (live && !done) begin
                chk("R9 irq per-cycle", {15'b0, irq}, {15'b0, mirq});
                chk(reg_addr == 3'd1 ? "R7 read per-cycle" :
                    reg_addr == 3'd0 ? "R2 read per-cycle" : "R4 read per-cycle",
                    reg_rdata, model_read(reg_addr));
            end
            pend = (|(mn & mnsig)) || (|(me & mesig));
            nclr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[8:0] : '0;
            eclr = (reg_wr && reg_addr == 3'd1) ? reg_wdata[EW-1:0] : '0;
            mn = (mn & ~nclr) | (norm_evt & mnen);
            me = (me & ~eclr) | (err_evt & meen);
            if (reg_wr && reg_addr == 3'd2) mnen  = reg_wdata[8:0];
            if (reg_wr && reg_addr == 3'd3) meen  = reg_wdata[EW-1:0];
            if (reg_wr && reg_addr == 3'd4) mnsig = reg_wdata[8:0];
            if (reg_wr && reg_addr == 3'd5) mesig = reg_wdata[EW-1:0];
            mirq = pend;
        end
    end

    task automatic cyc(input logic [8:0] ne, input logic [EW-1:0] ee,
                       input logic w, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        norm_evt = ne; err_evt = ee; reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc('0, '0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        norm_evt = '0; err_evt = '0; reg_wr = 1'b0; reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        chk(tag, {15'b0, irq}, {15'b0, exp});
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 16'h0, "R1 reset read");
        irq_is(1'b0, "R1 reset irq");
        // R3 nothing latched with enables clear
        cyc(9'h1FF, '1, 1'b0, 3'd0, 16'h0);
        rd(3'd0, 16'h0, "R3 normal masked");
        rd(3'd1, 16'h0, "R3 error masked");
        irq_is(1'b0, "R3 irq stays low");
        // R4 enable readback
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'h0001);
        wr(3'd5, 16'h0003);
        rd(3'd2, 16'h01FF, "R4 normal status enable");
        rd(3'd3, 16'h00FF, "R4 error status enable");
        rd(3'd4, 16'h0001, "R4 normal signal enable");
        rd(3'd5, 16'h0003, "R4 error signal enable");
        // R2 / R9
        cyc(9'h001, '0, 1'b0, 3'd0, 16'h0);
        rd(3'd0, 16'h0001, "R2 command done latched");
        irq_is(1'b0, "R9 irq lags status");
        rd(3'd0, 16'h0001, "R2 hold");
        irq_is(1'b1, "R9 irq raised");
        cyc(9'h040, '0, 1'b0, 3'd0, 16'h0);
        rd(3'd0, 16'h0041, "R2 card inserted latched");
        // R5 / R11
        wr(3'd0, 16'h0000);
        rd(3'd0, 16'h0041, "R5 zero write keeps");
        wr(3'd0, 16'h0001);
        rd(3'd0, 16'h0040, "R5 one clears bit0 only");
        irq_is(1'b1, "R11 irq one more cycle");
        rd(3'd0, 16'h0040, "R5 hold");
        irq_is(1'b0, "R11 irq dropped");
        // R6 set beats clear
        cyc(9'h002, '0, 1'b1, 3'd0, 16'h0002);
        rd(3'd0, 16'h0042, "R6 same-cycle event wins");
        wr(3'd0, 16'h01FF);
        rd(3'd0, 16'h0000, "R5 clear all");
        // R7 / R8 errors
        cyc('0, 8'h01, 1'b0, 3'd0, 16'h0);
        rd(3'd1, 16'h0001, "R7 command timeout");
        rd(3'd0, 16'h8000, "R8 summary set");
        irq_is(1'b1, "R9 error raises irq");
        cyc('0, 8'h02, 1'b0, 3'd0, 16'h0);
        rd(3'd1, 16'h0003, "R7 data timeout separate");
        wr(3'd0, 16'h8000);
        rd(3'd0, 16'h8000, "R8 summary ignores write");
        // R10 mask via error signal enable
        wr(3'd5, 16'h0000);
        rd(3'd1, 16'h0003, "R10 status kept");
        rd(3'd1, 16'h0003, "R10 status kept 2");
        irq_is(1'b0, "R10 irq masked");
        wr(3'd5, 16'h0003);
        rd(3'd1, 16'h0003, "R10 hold");
        rd(3'd1, 16'h0003, "R10 hold 2");
        irq_is(1'b1, "R10 irq back");
        wr(3'd1, 16'h0001);
        rd(3'd1, 16'h0002, "R5 error partial clear");
        wr(3'd1, 16'h00FF);
        rd(3'd0, 16'h0000, "R8 summary clears");
        // R3 per-bit masking
        wr(3'd2, 16'h01FE);
        cyc(9'h001, '0, 1'b0, 3'd0, 16'h0);
        rd(3'd0, 16'h0000, "R3 bit0 masked");
        // random phase, compared by the model
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 15);
            cyc(9'($urandom) & 9'($urandom), EW'($urandom) & EW'($urandom),
                r < 3, 3'($urandom_range(0, 6)), 16'($urandom));
        end
        cyc('0, '0, 1'b0, 3'd0, 16'h0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule